// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

A synchronous monostable. It takes three asynchronous control inputs: a trigger that fires on a falling edge, a trigger that fires on a rising edge, and an active-low clear. From these it produces a pulse of a programmable number of clock cycles on a true output and on its complement. Each input passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. Each of the three trigger paths is qualified by the levels of the other two inputs.

A qualified trigger loads the current value of `pulse_len` into a down-counter, and the output stays high while that counter is non-zero. A trigger that arrives during a pulse loads the counter again, so the pulse lasts a full width from the newest trigger. Holding clear low empties the counter and keeps the outputs idle. Releasing clear can itself start a pulse. A dual part is built from two instances.

Top module: `osm_oneshot`

## Requirements
- R1: A falling edge on `trig_fall` starts a pulse only when the synchronised `trig_rise` is 1 and the synchronised `clr_n` is 1 in the same cycle.
- R2: A rising edge on `trig_rise` starts a pulse only when the synchronised `trig_fall` is 0 and the synchronised `clr_n` is 1.
- R3: A rising edge on `clr_n` starts a pulse when the synchronised `trig_fall` is 0 and the synchronised `trig_rise` is 1.
- R4: While the synchronised `clr_n` is 0, the counter is emptied and, from the next clock edge on, `pulse_q` is 0. A pulse in progress ends there.
- R5: A qualified trigger during a pulse reloads `pulse_len`, so the pulse ends `pulse_len` cycles after the newest trigger.
- R6: With `trig_fall` held at 1, or `trig_rise` held at 0, toggling the other trigger input never starts a pulse.
- R7: `pulse_qn` is always the inverse of `pulse_q` once out of reset.
- R8: An input change made between rising clock edges k-1 and k raises `pulse_q` after edge k+2 when it forms a qualified trigger. `pulse_q` then stays high for exactly `pulse_len` clock cycles.
- R9: A trigger with `pulse_len` equal to 0 loads zero. No pulse starts, and a running pulse ends after the next clock edge.
- R10: While `rst_n` is 0 at a clock edge, the counter and the synchroniser flops clear, `pulse_q` becomes 0 and `pulse_qn` becomes 1. Because the clear synchroniser resets to 0, leaving reset with `clr_n` high is seen as a clear release (R3).
- R11: If a trigger edge and a falling edge of `clr_n` reach the synchronised levels in the same cycle, the clear takes effect and no pulse starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_fall | input | 1 | Asynchronous trigger, active on its falling edge |
| trig_rise | input | 1 | Asynchronous trigger, active on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear; its rising edge can also trigger |
| pulse_len | input | CNT_W | Pulse length in clock cycles, sampled on each trigger |
| pulse_q | output | 1 | True pulse output |
| pulse_qn | output | 1 | Complement pulse output |

## Verification
The assertions assume that `pulse_len` stays constant between a trigger and the cycle in which it is loaded. They also assume that each asynchronous input is held long enough to be captured by at least one clock edge. The stimulus meets both conditions by changing every input only on the falling clock edge, one value per cycle. Directed phases cover each gating combination, clear abort, retriggering, zero width and a same-cycle clear-versus-trigger race. A random phase follows, in which `pulse_len` is limited to small values so that pulses overlap often.

// File: rtl/osm_pkg.sv
// Package: shared types for the one-shot.
// Assumes: the three control inputs are always carried together in this order.
package osm_pkg;

    // Synchronised control levels, carried as one packed group.
    typedef struct packed {
        logic clr_n;
        logic rise;
        logic fall;
    } osm_lvl_t;

    localparam int unsigned OSM_NUM_IN = 3;

    // Which path produced a trigger (used for one-hot source vector).
    typedef enum logic [1:0] {
        SRC_FALL = 2'd0,
        SRC_RISE = 2'd1,
        SRC_CLR  = 2'd2
    } osm_src_e;

endpackage

// File: rtl/osm_sync.sv
// Module: multi-bit, multi-stage level synchroniser.
// Assumes: each bit is an independent slow level; no bus coherency is needed.
module osm_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Purpose: first capture flop of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[gi] <= RST_VAL;
                    else        stage[gi] <= async_in;
                end
            end else begin : g_next
                // Purpose: further metastability settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[gi] <= RST_VAL;
                    else        stage[gi] <= stage[gi-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage[STAGES-1];

endmodule

// File: rtl/osm_trigger.sv
// Module: edge detection and cross-gating of the three trigger paths.
// Assumes: inputs are already synchronised; one registered copy gives edges.
module osm_trigger
    import osm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  osm_lvl_t lvl,
    output logic     trig,
    output logic     clr_active,
    output logic [OSM_NUM_IN-1:0] src
);

    osm_lvl_t lvl_d;
    logic     fall_edge;
    logic     rise_edge;
    logic     clr_edge;

    // Purpose: keep previous-cycle levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    // Purpose: raw edges on each synchronised input.
    always_comb begin
        fall_edge = lvl_d.fall & ~lvl.fall;
        rise_edge = ~lvl_d.rise & lvl.rise;
        clr_edge  = ~lvl_d.clr_n & lvl.clr_n;
    end

    // Purpose: qualify each edge by the levels of the other two inputs.
    always_comb begin
        src           = '0;
        src[SRC_FALL] = fall_edge & lvl.rise  & lvl.clr_n;
        src[SRC_RISE] = rise_edge & ~lvl.fall & lvl.clr_n;
        src[SRC_CLR]  = clr_edge  & ~lvl.fall & lvl.rise;
    end

    // Purpose: merge the paths; clear level overrides any trigger.
    always_comb begin
        clr_active = ~lvl.clr_n;
        trig       = (|src) & ~clr_active;
    end

endmodule

// File: rtl/osm_counter.sv
// Module: width down-counter with registered true and complement outputs.
// Assumes: trig and clr_active are single-cycle qualified controls.
module osm_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             clr_active,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             q,
    output logic             q_n
);

    logic [CNT_W-1:0] count_nxt;
    logic             busy_nxt;

    // Purpose: next count: clear, reload on trigger, else run down to zero.
    always_comb begin
        if (clr_active)          count_nxt = '0;
        else if (trig)           count_nxt = load_val;
        else if (count != '0)    count_nxt = count - 1'b1;
        else                     count_nxt = count;
        busy_nxt = (count_nxt != '0);
    end

    // Purpose: counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

    // Purpose: registered output pair, each from its own flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            q   <= busy_nxt;
            q_n <= ~busy_nxt;
        end
    end

endmodule

// File: rtl/osm_oneshot.sv
// Module: retriggerable one-shot top level.
// Assumes: control inputs are asynchronous; pulse_len is quasi-static.
module osm_oneshot
    import osm_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fall,
    input  logic             trig_rise,
    input  logic             clr_n,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             pulse_q,
    output logic             pulse_qn
);

    localparam int unsigned IN_W = $bits(osm_lvl_t);

    osm_lvl_t               raw_lvl;
    osm_lvl_t               sync_lvl;
    logic [IN_W-1:0]        sync_bits;
    logic                   trig;
    logic                   clr_active;
    logic [OSM_NUM_IN-1:0]  trig_src;
    logic [CNT_W-1:0]       count;

    // Purpose: group the raw inputs.
    always_comb begin
        raw_lvl.fall  = trig_fall;
        raw_lvl.rise  = trig_rise;
        raw_lvl.clr_n = clr_n;
    end

    osm_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lvl),
        .sync_out (sync_bits)
    );

    assign sync_lvl = osm_lvl_t'(sync_bits);

    osm_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (sync_lvl),
        .trig       (trig),
        .clr_active (clr_active),
        .src        (trig_src)
    );

    osm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .clr_active (clr_active),
        .load_val   (pulse_len),
        .count      (count),
        .q          (pulse_q),
        .q_n        (pulse_qn)
    );

endmodule

// File: rtl/osm_oneshot_chk.sv
// Module: assertion checker bound to the one-shot top.
// Assumes: pulse_len is stable between trigger and load.
module osm_oneshot_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             clr_active,
    input logic [2:0]       trig_src,
    input logic [CNT_W-1:0] pulse_len,
    input logic [CNT_W-1:0] count,
    input logic             pulse_q,
    input logic             pulse_qn
);

    // R4: clear level leaves the output idle after the next edge.
    a_r4_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |=> (!pulse_q && count == '0));

    // R7: the two outputs are complementary.
    a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q != pulse_qn);

    // R5: a trigger loads the programmed width.
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == $past(pulse_len) && pulse_q == ($past(pulse_len) != '0)));

    // R8: without trigger or clear, a running count drops by one each cycle.
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !clr_active && count != '0) |=> (count == $past(count) - 1'b1));

    // R8: an idle counter with no trigger stays idle.
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && count == '0) |=> (!pulse_q && count == '0));

    // R11: clear masks every trigger source.
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |-> !trig);

    // R10: reset leaves the outputs idle.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!pulse_q && pulse_qn));

endmodule

bind osm_oneshot osm_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .clr_active (clr_active),
    .trig_src   (trig_src),
    .pulse_len  (pulse_len),
    .count      (count),
    .pulse_q    (pulse_q),
    .pulse_qn   (pulse_qn)
);

// File: tb/osm_oneshot_tb.sv
// Bench: behavioural reference model compared every clock.
module osm_oneshot_tb;

    localparam int unsigned CNT_W   = 8;
    localparam time         CLK_PER = 10ns;
    localparam int          WDOG    = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_fall = 1'b1;
    logic             trig_rise = 1'b1;
    logic             clr_n = 1'b1;
    logic [CNT_W-1:0] pulse_len = 8'd5;
    logic             pulse_q;
    logic             pulse_qn;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    string phase = "R10";

    // model state: history queues, index 0 newest
    int hf[$];
    int hr[$];
    int hc[$];
    int mcnt = 0;
    bit exp_q = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    osm_oneshot #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_fall (trig_fall),
        .trig_rise (trig_rise),
        .clr_n     (clr_n),
        .pulse_len (pulse_len),
        .pulse_q   (pulse_q),
        .pulse_qn  (pulse_qn)
    );

    // reference model
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            hf = '{0, 0, 0};
            hr = '{0, 0, 0};
            hc = '{0, 0, 0};
            mcnt = 0;
        end else begin
            bit go;
            go = 1'b0;
            if (hf[2] == 1 && hf[1] == 0 && hr[1] == 1 && hc[1] == 1) go = 1'b1;
            if (hr[2] == 0 && hr[1] == 1 && hf[1] == 0 && hc[1] == 1) go = 1'b1;
            if (hc[2] == 0 && hc[1] == 1 && hf[1] == 0 && hr[1] == 1) go = 1'b1;
            if (hc[1] == 0)      mcnt = 0;
            else if (go)         mcnt = int'(pulse_len);
            else if (mcnt > 0)   mcnt = mcnt - 1;
            hf.push_front(int'(trig_fall)); void'(hf.pop_back());
            hr.push_front(int'(trig_rise)); void'(hr.pop_back());
            hc.push_front(int'(clr_n));     void'(hc.pop_back());
        end
        exp_q = (mcnt > 0);
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            n_vec++;
            if (pulse_q !== exp_q || pulse_qn !== !exp_q) begin
                n_bad++;
                $display("FAIL %s cyc=%0d q=%b qn=%b expected q=%b qn=%b",
                         phase, cyc, pulse_q, pulse_qn, exp_q, !exp_q);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic f, input logic r, input logic c);
        trig_fall = f;
        trig_rise = r;
        clr_n     = c;
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        // R10: reset state
        step(3);
        n_vec++;
        if (pulse_q !== 1'b0 || pulse_qn !== 1'b1) begin
            n_bad++;
            $display("FAIL R10 q=%b qn=%b expected q=0 qn=1", pulse_q, pulse_qn);
        end
        cmp_on = 1'b1;
        rst_n  = 1'b1;
        step(10);

        // R1 / R8: falling trigger with rise high, clear high
        phase = "R1"; pulse_len = 8'd5;
        drive(1, 1, 1); step(4);
        drive(0, 1, 1); step(12);

        // R2: rising trigger with fall low
        phase = "R2"; pulse_len = 8'd7;
        drive(0, 0, 1); step(4);
        drive(0, 1, 1); step(14);

        // R3: clear release triggers
        phase = "R3"; pulse_len = 8'd4;
        drive(0, 1, 0); step(5);
        drive(0, 1, 1); step(10);

        // R4: clear aborts a running pulse
        phase = "R4"; pulse_len = 8'd30;
        drive(1, 1, 1); step(4);
        drive(0, 1, 1); step(8);
        drive(0, 1, 0); step(6);
        drive(1, 1, 0); step(3);
        drive(1, 1, 1); step(6);

        // R5: retrigger extends
        phase = "R5"; pulse_len = 8'd9;
        drive(0, 0, 1); step(3);
        drive(0, 1, 1); step(5);
        drive(0, 0, 1); step(2);
        drive(0, 1, 1); step(6);
        drive(0, 0, 1); step(1);
        drive(0, 1, 1); step(15);

        // R6: inhibit by fall held high / rise held low
        phase = "R6"; pulse_len = 8'd6;
        drive(1, 0, 1); step(3);
        for (int i = 0; i < 4; i++) begin drive(1, 1, 1); step(2); drive(1, 0, 1); step(2); end
        for (int i = 0; i < 4; i++) begin drive(0, 0, 1); step(2); drive(1, 0, 1); step(2); end
        drive(1, 0, 0); step(2); drive(1, 0, 1); step(6);

        // R7 / R8: long pulse
        phase = "R8"; pulse_len = 8'd200;
        drive(1, 1, 1); step(3);
        drive(0, 1, 1); step(210);

        // R9: zero width, alone and during a pulse
        phase = "R9"; pulse_len = 8'd0;
        drive(1, 1, 1); step(3);
        drive(0, 1, 1); step(6);
        pulse_len = 8'd20;
        drive(1, 1, 1); step(3);
        drive(0, 1, 1); step(5);
        pulse_len = 8'd0;
        drive(1, 1, 1); step(1);
        drive(0, 1, 1); step(1);
        drive(0, 0, 1); step(8);

        // R11: trigger edge and clear fall together
        phase = "R11"; pulse_len = 8'd6;
        drive(1, 1, 1); step(4);
        drive(0, 1, 0); step(8);
        drive(0, 0, 0); step(2);
        drive(0, 1, 1); step(10);
        drive(0, 0, 1); step(3);
        drive(0, 1, 0); step(10);
        drive(0, 1, 1); step(10);

        // mixed random traffic across R1 R2 R3 R4 R5
        phase = "R5";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] rv;
            rv = 4'($urandom);
            pulse_len = 8'($urandom_range(0, 12));
            drive(rv[0], rv[1], (rv[3:2] != 2'b00));
            step(int'($urandom_range(1, 4)));
        end
        drive(1, 1, 1); step(20);

        // R10: mid-run reset returns to idle
        phase = "R10"; pulse_len = 8'd50;
        drive(0, 1, 1); step(3);
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(20);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule